// File: doc/BRIEF.md
# Dual-Enable Static Memory Core

This block is a synthesizable model of a byte-wide static memory controlled by two chip enables, one active low (`ce_n`) and one active high (`ce`), together with an active-low write strobe (`we_n`) and an active-low output enable (`oe_n`). The bidirectional data bus is split into `din`, `dout` and a `drive_en` flag. The flag tells the surrounding logic when the memory would be driving the bus, so the block needs no tri-state logic.

The pins are asynchronous, so a two-flop synchronizer samples all of them on a fast system clock. A state machine decodes each synchronized sample into one of four states: `ST_STANDBY`, `ST_OUTDIS`, `ST_READ` and `ST_WRITE`. Any state may move to any other on the next sample, as the decoded pins dictate.

On every cycle spent in `ST_WRITE`, the machine captures the address and data. The transition out of `ST_WRITE` into any other state is the commit transition. On that transition the captured word is stored. A write can therefore end with `we_n` rising or with either chip enable going inactive, whichever comes first. The array depth is `2**ADDR_W`. The default of 10 address bits keeps elaboration small. Setting `ADDR_W = 17` gives the full 131,072-word array.

Top module: `sram_dual_en`

## Requirements
- R1: The array holds `2**ADDR_W` words of `DATA_W` bits (defaults 10 and 8), and a word written to an address is returned by a later read of that address.
- R2: When `ce_n` is 1 or `ce` is 0, the block is in standby. `drive_en` is 0, and a low `we_n` writes nothing.
- R3: With `ce_n`=0, `ce`=1, `we_n`=1 and `oe_n`=1, the block is in output-disable and `drive_en` is 0.
- R4: With `ce_n`=0, `ce`=1, `we_n`=1 and `oe_n`=0, `drive_en` is 1 and `dout` equals the word at `addr`. Both outputs reflect pin values held for three clock edges.
- R5: A write requires `ce_n`=0, `ce`=1 and `we_n`=0, with `oe_n` either 0 or 1. While the write is in progress, `drive_en` is 0.
- R6: A write ended by `we_n` rising stores the word.
- R7: A write ended by `ce_n` rising, or by `ce` falling, stores the word.
- R8: The stored address and data are those present before the ending edge. Changes to `addr` or `din` made together with the ending edge are ignored.
- R9: While `drive_en` is 0, `dout` is 0.
- R10: After reset, `drive_en` and `dout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data from the bus |
| ce_n | input | 1 | Chip enable, active low |
| ce | input | 1 | Chip enable, active high |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| dout | output | DATA_W | Read data for the bus |
| drive_en | output | 1 | High when the memory would drive the bus |

## Verification
The hardest case to reach is a write ended by a chip enable while `we_n` is still low, with the address and data changing on the same sample. Only the capture from the previous cycle protects the stored word in that case. The random stimulus chooses one of the three ending pins for every write and replaces `addr` and `din` with unrelated values on the ending edge. Each written word is then read back against a bench model. Directed steps attempt writes in both standby forms and confirm that the target word is unchanged.

// File: rtl/sram_dual_en_pkg.sv
package sram_dual_en_pkg;
    typedef enum logic [1:0] {
        ST_STANDBY,
        ST_OUTDIS,
        ST_READ,
        ST_WRITE
    } state_t;
endpackage

// File: rtl/sram_sync.sv
module sram_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_dual_en_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n_s,
    input  logic              ce_s,
    input  logic              we_n_s,
    input  logic              oe_n_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] din_s,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              rd_en,
    output logic              drive_en
);
    state_t state, state_nx;

    // decode the synchronized pins into the next state
    always_comb begin
        if (ce_n_s || !ce_s)  state_nx = ST_STANDBY;
        else if (!we_n_s)     state_nx = ST_WRITE;
        else if (!oe_n_s)     state_nx = ST_READ;
        else                  state_nx = ST_OUTDIS;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_STANDBY;
        else        state <= state_nx;
    end

    // outputs: commit strobe on leaving ST_WRITE, read select, bus drive flag
    always_comb begin
        mem_we = 1'b0;
        rd_en  = 1'b0;
        unique case (state)
            ST_WRITE:   mem_we = (state_nx != ST_WRITE);
            ST_STANDBY,
            ST_OUTDIS,
            ST_READ:    mem_we = 1'b0;
        endcase
        rd_en = (state_nx == ST_READ);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_en  <= 1'b0;
            mem_waddr <= '0;
            mem_wdata <= '0;
        end else begin
            drive_en <= rd_en;
            if (state_nx == ST_WRITE) begin
                mem_waddr <= addr_s;
                mem_wdata <= din_s;
            end
        end
    end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
        else         rdata <= '0;
    end
endmodule

// File: rtl/sram_dual_en.sv
module sram_dual_en #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              ce_n,
    input  logic              ce,
    input  logic              we_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dout,
    output logic              drive_en
);
    localparam int BUS_W = 4 + ADDR_W + DATA_W;
    localparam logic [BUS_W-1:0] BUS_RST = {4'b1011, {(ADDR_W + DATA_W){1'b0}}};

    logic [BUS_W-1:0]  raw_bus, syn_bus;
    logic              ce_n_s, ce_s, we_n_s, oe_n_s;
    logic [ADDR_W-1:0] addr_s, waddr;
    logic [DATA_W-1:0] din_s, wdata;
    logic              mem_we, rd_en;

    assign raw_bus = {ce_n, ce, we_n, oe_n, addr, din};
    assign {ce_n_s, ce_s, we_n_s, oe_n_s, addr_s, din_s} = syn_bus;

    sram_sync #(.W(BUS_W), .RST_VAL(BUS_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(syn_bus)
    );

    sram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ce_n_s(ce_n_s), .ce_s(ce_s), .we_n_s(we_n_s), .oe_n_s(oe_n_s),
        .addr_s(addr_s), .din_s(din_s),
        .mem_we(mem_we), .mem_waddr(waddr), .mem_wdata(wdata),
        .rd_en(rd_en), .drive_en(drive_en)
    );

    sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .we(mem_we), .waddr(waddr), .wdata(wdata),
        .re(rd_en), .raddr(addr_s), .rdata(dout)
    );
endmodule

// File: rtl/sram_dual_en_chk.sv
module sram_dual_en_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              ce,
    input logic              we_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] dout,
    input logic              drive_en
);
    logic [1:0] warm;
    logic       ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end
    assign ready = (warm == 2'd3);

    // R4
    drive_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && drive_en) |-> $past(!ce_n && ce && we_n && !oe_n, 3));

    // R5
    write_blocks_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(!ce_n && ce && !we_n, 3)) |-> !drive_en);

    // R2
    standby_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ce_n || !ce, 3)) |-> !drive_en);

    // R3
    outdis_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(!ce_n && ce && we_n && oe_n, 3)) |-> !drive_en);

    // R9
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |-> (dout == '0));
endmodule

bind sram_dual_en sram_dual_en_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ce(ce), .we_n(we_n),
    .oe_n(oe_n), .dout(dout), .drive_en(drive_en)
);

// File: tb/sram_dual_en_tb.sv
module sram_dual_en_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          ce_n = 1'b1, ce = 1'b0, we_n = 1'b1, oe_n = 1'b1;
    logic [DW-1:0] dout;
    logic          drive_en;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [DEPTH];
    bit            known [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_dual_en #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
        .ce_n(ce_n), .ce(ce), .we_n(we_n), .oe_n(oe_n),
        .dout(dout), .drive_en(drive_en)
    );

    function automatic logic [DW-1:0] expect_word(input logic [AW-1:0] a);
        return model[a];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic standby();
        ce_n = 1'b1; ce = 1'b0; we_n = 1'b1; oe_n = 1'b1;
        hold(4);
    endtask

    // end_sel: 0 = we_n rises, 1 = ce_n rises, 2 = ce falls
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input int end_sel, input logic oe_v);
        ce_n = 1'b0; ce = 1'b1; we_n = 1'b0; oe_n = oe_v;
        addr = a; din = d;
        hold(4);
        check(drive_en == 1'b0, "R5", drive_en, 0);
        // R8: scramble address and data on the ending edge
        addr = a ^ AW'(1 + $urandom_range(0, DEPTH - 2));
        din  = ~d;
        unique case (end_sel)
            0: we_n = 1'b1;
            1: ce_n = 1'b1;
            default: ce = 1'b0;
        endcase
        hold(4);
        standby();
        model[a] = d;
        known[a] = 1'b1;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string req);
        ce_n = 1'b0; ce = 1'b1; we_n = 1'b1; oe_n = 1'b0; addr = a;
        hold(4);
        check(drive_en == 1'b1, "R4", drive_en, 1);
        check(dout == expect_word(a), req, dout, expect_word(a));
        standby();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        int unused_seed;
        unused_seed = $urandom(32'd4711);
        for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;
        hold(3);
        // R10 reset state
        check(drive_en == 1'b0, "R10", drive_en, 0);
        check(dout == '0, "R10", dout, 0);
        rst_n = 1'b1;
        hold(4);
        check(drive_en == 1'b0, "R10", drive_en, 0);

        // R6, R7, R8 with each ending pin
        do_write(10'h001, 8'hA5, 0, 1'b1);
        do_read(10'h001, "R6");
        do_write(10'h002, 8'h3C, 1, 1'b0);
        do_read(10'h002, "R7");
        do_write(10'h003, 8'hC3, 2, 1'b1);
        do_read(10'h003, "R7");
        do_read(10'h001, "R8");
        // R1 corner addresses
        do_write(10'h000, 8'h11, 0, 1'b0);
        do_write(10'h3FF, 8'hEE, 1, 1'b1);
        do_read(10'h000, "R1");
        do_read(10'h3FF, "R1");

        // R3 output-disable and R9
        ce_n = 1'b0; ce = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = 10'h001;
        hold(4);
        check(drive_en == 1'b0, "R3", drive_en, 0);
        check(dout == '0, "R9", dout, 0);

        // R2 standby forms with we_n low and oe_n low: no drive, no write
        ce_n = 1'b1; ce = 1'b1; we_n = 1'b0; oe_n = 1'b0; addr = 10'h001; din = 8'h00;
        hold(4);
        check(drive_en == 1'b0, "R2", drive_en, 0);
        check(dout == '0, "R9", dout, 0);
        ce_n = 1'b0; ce = 1'b0;
        hold(4);
        check(drive_en == 1'b0, "R2", drive_en, 0);
        we_n = 1'b1;
        hold(4);
        standby();
        do_read(10'h001, "R2");

        // random mix
        for (int n = 0; n < 120; n++) begin
            logic [AW-1:0] ra;
            ra = AW'($urandom_range(0, DEPTH - 1));
            if (!known[ra] || ($urandom_range(0, 1) == 0))
                do_write(ra, DW'($urandom), int'($urandom_range(0, 2)), 1'($urandom));
            else
                do_read(ra, "R1");
        end
        for (int i = 0; i < DEPTH; i += 37)
            if (known[i]) do_read(AW'(i), "R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule